// File: doc/BRIEF.md
# External Bus Sequencer with Read-to-Write Turnaround

This block runs fixed-length external bus cycles for a CPU. The CPU raises a request with a direction, a target area, an address and, for a write, the write data, and keeps it stable until the block answers with a one-clock ready pulse. The block drives the address lines, an active-low chip select for the selected area, the active-low read and write strobes, and the data-bus output enable. A read takes three bus states and a write takes two.

Some slow devices keep driving the data bus for a while after their read strobe goes away. If a write starts straight after such a read, the write data and the late read data collide on the bus. To avoid this, the block remembers what kind of cycle it ran last. When a write request arrives right after a read and the turnaround enable is set, it inserts one idle bus state before the write starts. During that state nothing is selected and the block does not drive the bus. The enable is on after reset and can be changed with a configuration write.

Requests are handled as follows. A request that arrives while the bus is idle starts its first state in that same clock; its outputs come straight from the held request. The CPU may present its next request in the clock right after ready, and that counts as directly following. A clock with the bus idle and no request pending clears the record of the previous cycle.

Top module: `xbus_turnaround_seq`

## Requirements
- R1: After reset all chip selects, the read strobe and the write strobe are high (inactive), the output enable and ready are low, and the turnaround enable is 1.
- R2: A read drives the selected area's chip select low and the read strobe low in each of its three states, presents the request address, and pulses ready only in the third state.
- R3: A write keeps the read strobe high and drives its chip select low for two states. It drives the output enable and the write data in both states, pulls the write strobe low only in the second state, and pulses ready only in the second state.
- R4: With the enable at 1, a write request presented in the clock after a read's ready is preceded by exactly one idle bus state, and its first write state follows in the next clock.
- R5: With the enable at 0, a write presented in the clock after a read's ready starts its first state in that clock, with no idle state.
- R6: Insertion applies when the read and the following write target different areas; at most one chip select is low at any time.
- R7: In the inserted idle state all chip selects and both strobes are high, the output enable is low, and ready is low.
- R8: The output enable is high only in write states, never during read states, idle states or an empty bus.
- R9: A read after a read, a read after a write, a write after a write, and a write on a bus with no earlier access since reset start with no idle state.
- R10: After at least one clock with the bus idle and no request, a write that follows an earlier read starts with no idle state.
- R11: A read captures the data bus in its third state; the captured value is on the read-data output from the next clock on.
- R12: A configuration write sets the turnaround enable to the supplied bit from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the turnaround enable |
| cfg_turn_en | input | 1 | New turnaround enable value |
| req_valid | input | 1 | Request pending, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_area | input | AREA_W | Target chip-select area |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | One-clock pulse in the last bus state |
| rsp_rdata | output | DATA_W | Data captured by the last read |
| bus_addr | output | ADDR_W | External address, zero when no cycle is active |
| bus_cs_n | output | AREA_N | Active-low chip select per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_hwr_n | output | 1 | Active-low write strobe |
| bus_d_o | output | DATA_W | Data driven onto the bus |
| bus_d_oe | output | 1 | Data output enable |
| bus_d_i | input | DATA_W | Data sampled from the bus |

## Verification
All strobes, chip selects, the output enable and ready follow the bus state in the same clock. The first state of a cycle appears in the clock in which its request is presented on an idle bus, so the bench drives each request on the falling edge and reads the outputs shortly afterwards, once per clock until ready. It counts the idle states before the first selected state and checks the strobe pattern in each state against the state number. Read data and the turnaround enable are registered and take effect one clock later: read data is checked just after the edge that ends the third read state, and a configuration write is made at least one full clock before the next request.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

    // Bus state of the sequencer; ST_TI is the inserted turnaround state
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TI   = 3'd4
    } bus_st_e;

    // Kind of the most recently completed external cycle
    typedef enum logic [1:0] {
        PREV_NONE = 2'd0,
        PREV_RD   = 2'd1,
        PREV_WR   = 2'd2
    } prev_e;

endpackage

// File: rtl/xbus_cs_decode.sv
module xbus_cs_decode #(
    parameter int AREA_N = 4,
    parameter int AREA_W = 2
) (
    input  logic              active,
    input  logic [AREA_W-1:0] area,
    output logic [AREA_N-1:0] cs_n
);

    // One active-low select per area, low only while a bus state is active
    for (genvar gi = 0; gi < AREA_N; gi++) begin : g_area
        assign cs_n[gi] = !(active && (area == AREA_W'(gi)));
    end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_seq_pkg::*;
(
    input  bus_st_e st,
    input  logic    is_write,
    output logic    active,
    output logic    rd_n,
    output logic    hwr_n,
    output logic    d_oe,
    output logic    last
);

    always_comb begin
        active = (st == ST_T1) || (st == ST_T2) || (st == ST_T3);
        rd_n   = !(active && !is_write);
        hwr_n  = !(is_write && (st == ST_T2));
        d_oe   = is_write && ((st == ST_T1) || (st == ST_T2));
        if (is_write) begin
            last = (st == ST_T2);
        end else begin
            last = (st == ST_T3);
        end
    end

endmodule

// File: rtl/xbus_turn_track.sv
module xbus_turn_track
    import xbus_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_turn_en,
    input  logic bus_idle,
    input  logic req_valid,
    input  logic req_write,
    input  logic cyc_done,
    output logic insert
);

    typedef struct packed {
        logic  en;
        prev_e prev;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (cfg_we) begin
            trk_d.en = cfg_turn_en;
        end
        if (cyc_done) begin
            trk_d.prev = req_write ? PREV_WR : PREV_RD;
        end else if (bus_idle && !req_valid) begin
            trk_d.prev = PREV_NONE;
        end
        insert = trk_q.en && req_write && (trk_q.prev == PREV_RD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q.en   <= 1'b1;
            trk_q.prev <= PREV_NONE;
        end else begin
            trk_q <= trk_d;
        end
    end

endmodule

// File: rtl/xbus_turnaround_seq.sv
module xbus_turnaround_seq
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int AREA_N = 4,
    localparam int AREA_W = (AREA_N > 1) ? $clog2(AREA_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_turn_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AREA_W-1:0] req_area,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [AREA_N-1:0] bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_hwr_n,
    output logic [DATA_W-1:0] bus_d_o,
    output logic              bus_d_oe,
    input  logic [DATA_W-1:0] bus_d_i
);

    typedef struct packed {
        bus_st_e           st;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t    seq_d, seq_q;
    bus_st_e st_cur;
    logic    bus_idle;
    logic    insert;
    logic    active;
    logic    last;

    assign bus_idle = (seq_q.st == ST_IDLE);

    xbus_turn_track i_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_turn_en(cfg_turn_en),
        .bus_idle   (bus_idle),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .cyc_done   (last),
        .insert     (insert)
    );

    // A request on an idle bus starts its first state (or the turnaround
    // state) in the same clock; otherwise the registered state applies.
    always_comb begin
        if (bus_idle && req_valid) begin
            st_cur = insert ? ST_TI : ST_T1;
        end else begin
            st_cur = seq_q.st;
        end
    end

    xbus_strobe_gen i_strobe (
        .st      (st_cur),
        .is_write(req_write),
        .active  (active),
        .rd_n    (bus_rd_n),
        .hwr_n   (bus_hwr_n),
        .d_oe    (bus_d_oe),
        .last    (last)
    );

    xbus_cs_decode #(
        .AREA_N(AREA_N),
        .AREA_W(AREA_W)
    ) i_cs (
        .active(active),
        .area  (req_area),
        .cs_n  (bus_cs_n)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (st_cur)
            ST_TI:   seq_d.st = ST_T1;
            ST_T1:   seq_d.st = ST_T2;
            ST_T2:   seq_d.st = req_write ? ST_IDLE : ST_T3;
            ST_T3:   seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
        if (st_cur == ST_T3) begin
            seq_d.rdata = bus_d_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.rdata <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = last;
    assign rsp_rdata = seq_q.rdata;
    assign bus_addr  = active ? req_addr : '0;
    assign bus_d_o   = bus_d_oe ? req_wdata : '0;

endmodule

// File: rtl/xbus_turnaround_seq_chk.sv
module xbus_turnaround_seq_chk #(
    parameter int AREA_N = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_write,
    input logic              req_ready,
    input logic [AREA_N-1:0] bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_hwr_n,
    input logic              bus_d_oe
);

    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe |-> (req_write && bus_rd_n && !(&bus_cs_n))); // R8

    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_hwr_n) |-> !(&bus_cs_n)); // R7

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n)); // R6

    AST_READY_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(&bus_cs_n)); // R2

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R3

    AST_HWR_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hwr_n |-> ($past(bus_d_oe) && bus_d_oe)); // R3

endmodule

bind xbus_turnaround_seq xbus_turnaround_seq_chk #(
    .AREA_N(AREA_N)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_write(req_write),
    .req_ready(req_ready),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_hwr_n(bus_hwr_n),
    .bus_d_oe (bus_d_oe)
);

// File: tb/test_xbus_turnaround_seq.sv
`timescale 1ns/1ps
module test_xbus_turnaround_seq;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int AN = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we, cfg_turn_en;
    logic          req_valid, req_write;
    logic [1:0]    req_area;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic          req_ready;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] bus_addr;
    logic [AN-1:0] bus_cs_n;
    logic          bus_rd_n, bus_hwr_n, bus_d_oe;
    logic [DW-1:0] bus_d_o, bus_d_i;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    xbus_turnaround_seq #(.ADDR_W(AW), .DATA_W(DW), .AREA_N(AN)) i_xbus_turnaround_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_turn_en(cfg_turn_en),
        .req_valid(req_valid), .req_write(req_write), .req_area(req_area),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_hwr_n(bus_hwr_n), .bus_d_o(bus_d_o),
        .bus_d_oe(bus_d_oe), .bus_d_i(bus_d_i)
    );

    typedef struct packed {
        logic       en;
        logic       a_wr;
        logic       b_wr;
        logic [1:0] a_area;
        logic [1:0] b_area;
        logic [1:0] gap;
        logic       exp_ins;
    } vec_t;

    // en, first op, second op, areas, idle clocks between, idle state expected
    localparam vec_t VECS [0:7] = '{
        '{1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 1'b1},  // R4
        '{1'b1, 1'b0, 1'b1, 2'd1, 2'd3, 2'd0, 1'b1},  // R6
        '{1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd0, 1'b0},  // R5
        '{1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 2'd0, 1'b0},  // R9 read-read
        '{1'b1, 1'b1, 1'b1, 2'd3, 2'd2, 2'd0, 1'b0},  // R9 write-write
        '{1'b1, 1'b1, 1'b0, 2'd1, 2'd0, 2'd0, 1'b0},  // R9 write-read
        '{1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 2'd1, 1'b0},  // R10
        '{1'b1, 1'b0, 1'b1, 2'd3, 2'd0, 2'd2, 1'b0}   // R10
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; cfg_turn_en = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_area = '0;
        req_addr = '0; req_wdata = '0; bus_d_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b1; cfg_turn_en = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle_clocks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // Runs one bus cycle; counts idle states before the first selected
    // state, selected states, and strobe or address errors per state.
    task automatic do_op(input bit wr, input logic [1:0] area, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                         output int idle_n, output int st_n, output int errs);
        idle_n = 0; st_n = 0; errs = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_area = area;
        req_addr = addr; req_wdata = wd; bus_d_i = rd;
        forever begin
            #1;
            if (&bus_cs_n) begin
                idle_n++;
                if (!bus_rd_n || !bus_hwr_n || bus_d_oe || req_ready) errs++;
                if (idle_n > 4) break;
            end else begin
                st_n++;
                if (bus_cs_n != ~(AN'(1) << area)) errs++;
                if (bus_addr != addr) errs++;
                if (wr) begin
                    if (!bus_rd_n || !bus_d_oe || bus_d_o != wd) errs++;
                    if (bus_hwr_n != (st_n != 2)) errs++;
                    if (req_ready != (st_n == 2)) errs++;
                end else begin
                    if (bus_rd_n || !bus_hwr_n || bus_d_oe) errs++;
                    if (req_ready != (st_n == 3)) errs++;
                end
                if (req_ready || st_n > 4) begin
                    @(posedge clk);
                    break;
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int in_a, sn_a, er_a, in_b, sn_b, er_b;
        do_reset();
        // R1: reset state, sampled away from the edge
        #1;
        check(&bus_cs_n && bus_rd_n && bus_hwr_n, "R1 strobes idle",
              int'({bus_cs_n, bus_rd_n, bus_hwr_n}), 63);
        check(!bus_d_oe && !req_ready, "R1 oe/ready low", int'({bus_d_oe, req_ready}), 0);

        // R9: write on a bus with no earlier access since reset
        do_op(1'b1, 2'd2, 16'h0040, 16'h1234, 16'h0, in_b, sn_b, er_b);
        check(in_b == 0, "R9 write after reset idle states", in_b, 0);
        check(sn_b == 2 && er_b == 0, "R3 write states", sn_b * 100 + er_b, 200);

        // R1/R4: enable is 1 after reset, read then write inserts one state
        do_reset();
        do_op(1'b0, 2'd1, 16'h0100, 16'h0, 16'hBEEF, in_a, sn_a, er_a);
        #1;
        check(rsp_rdata == 16'hBEEF, "R11 read data", int'(rsp_rdata), 16'hBEEF);
        check(sn_a == 3 && er_a == 0, "R2 read states", sn_a * 100 + er_a, 300);
        do_op(1'b1, 2'd1, 16'h0102, 16'h5A5A, 16'h0, in_b, sn_b, er_b);
        check(in_b == 1, "R1 default enable inserts", in_b, 1);
        check(er_b == 0, "R7 idle state quiet", er_b, 0);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            vec_t v;
            logic [AW-1:0] ad;
            v  = VECS[i];
            ad = 16'h1000 + AW'(i) * 16'h0111;
            set_en(v.en);  // R12: takes effect before the next request
            idle_clocks(1);
            do_op(v.a_wr, v.a_area, ad, 16'hA5A5 ^ DW'(i), 16'h3C00 + DW'(i), in_a, sn_a, er_a);
            check(in_a == 0 && er_a == 0, "R2/R3 first op clean", in_a * 100 + er_a, 0);
            check(sn_a == (v.a_wr ? 2 : 3), "R2/R3 first op length", sn_a, v.a_wr ? 2 : 3);
            if (!v.a_wr) begin
                #1;
                check(rsp_rdata == 16'h3C00 + DW'(i), "R11 captured data",
                      int'(rsp_rdata), 16'h3C00 + i);
            end
            if (v.gap != 0) idle_clocks(int'(v.gap));
            do_op(v.b_wr, v.b_area, ad + 16'h8, 16'h0F0F + DW'(i), 16'h4400 + DW'(i), in_b, sn_b, er_b);
            check(in_b == int'(v.exp_ins), "R4/R5/R6/R9/R10 idle states", in_b, int'(v.exp_ins));
            check(er_b == 0, "R7/R8 strobe pattern", er_b, 0);
            check(sn_b == (v.b_wr ? 2 : 3), "R2/R3 second op length", sn_b, v.b_wr ? 2 : 3);
        end

        // R12: re-enable after clearing, insertion returns
        set_en(1'b0);
        set_en(1'b1);
        do_op(1'b0, 2'd3, 16'h0200, 16'h0, 16'h7777, in_a, sn_a, er_a);
        do_op(1'b1, 2'd0, 16'h0204, 16'h8888, 16'h0, in_b, sn_b, er_b);
        check(in_b == 1 && er_b == 0, "R12 re-enabled insertion", in_b * 100 + er_b, 100);

        // R5: enable cleared, write follows read with no gap
        set_en(1'b0);
        do_op(1'b0, 2'd0, 16'h0300, 16'h0, 16'h1111, in_a, sn_a, er_a);
        do_op(1'b1, 2'd3, 16'h0304, 16'h2222, 16'h0, in_b, sn_b, er_b);
        check(in_b == 0 && sn_b == 2, "R5 no insertion", in_b * 100 + sn_b, 2);

        // R8: empty bus, no output enable
        idle_clocks(2);
        #1;
        check(!bus_d_oe && (&bus_cs_n), "R8 empty bus", int'(bus_d_oe), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule